// File: doc/BRIEF.md
# AGC Update Synchronization Controller

This block decides when an automatic gain control loop gets a fresh update sample from its decimating power filter, and when the loop's parameters are loaded again from their staged copies. A sync request comes from a pin or from software. It starts a programmable countdown. When the countdown reaches one, the block raises an update strobe for the filter. The same cycle can also carry an initialize strobe. That strobe clears the filter and loads the staged decimation ratio, averaging count, filter scale, signal gain, loop gain and pole into the active loop.

A control write sets several things at once:
- whether every effective sync also reinitializes the loop;
- whether only the first sync after the write is honoured;
- whether the update is forced at once, with no external sync;
- whether the gain stage is bypassed;
- which tracking mode the downstream loop uses.

The gain arithmetic and the filters are not part of this block.

Top module: `agc_sync_unit`

## Requirements
- R1: After reset, updateStrobe, initStrobe, bypassOut and clipModeOut are all 0, and no countdown is running.
- R2: A sync request is a high pinSync or a high softSync, sampled on a rising edge. When it is accepted with holdoffVal = H (H >= 2), updateStrobe is high for exactly one cycle. That cycle begins H-1 rising edges after the sampling edge. The strobe is low in every other cycle of the window.
- R3: When an accepted sync has holdoffVal = 1, updateStrobe is high in the cycle that starts at the sampling edge itself.
- R4: When holdoffVal is 0, a sync is never accepted and produces no strobe.
- R5: A sync that is accepted while a countdown is running reloads the counter with the current holdoffVal and restarts the count. The earlier countdown then produces no strobe.
- R6: A control write with cfgForce = 1 raises updateStrobe in the cycle that starts at the write edge. No sync is needed.
- R7: initStrobe is high exactly when updateStrobe is high and the init-on-sync setting (cfgInitOnSync, stored by the last control write) is 1. If that setting is 0, updateStrobe still pulses but initStrobe stays low.
- R8: If the first-only setting (cfgFirstOnly) is 1, only the first accepted sync after the control write takes effect. Later syncs are ignored until the next control write, which clears the record of a seen sync.
- R9: bypassOut and clipModeOut take the values of cfgBypass and cfgClipMode on the control-write edge. They hold those values until the next write. clipModeOut = 0 selects constant-output-level tracking; 1 selects constant-clipping-error tracking.
- R10: A sync request in the same cycle as a control write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinSync | input | 1 | Sync request from the external pin |
| softSync | input | 1 | Sync request from software |
| holdoffVal | input | CNT_W | Countdown load value (0 disables sync) |
| cfgWrite | input | 1 | Control register write strobe |
| cfgForce | input | 1 | Immediate update command (with cfgWrite) |
| cfgInitOnSync | input | 1 | Reinitialize the loop on each effective sync |
| cfgFirstOnly | input | 1 | Honour only the first sync after a write |
| cfgBypass | input | 1 | Bypass the gain stage |
| cfgClipMode | input | 1 | Tracking mode select |
| updateStrobe | output | 1 | One-cycle update sample request to the filter |
| initStrobe | output | 1 | One-cycle filter clear and parameter reload |
| bypassOut | output | 1 | Registered bypass flag |
| clipModeOut | output | 1 | Registered tracking mode |

## Verification
The strobes come from a counter register that is decoded directly. An accepted sync with holdoff H therefore shows its strobe in the cycle that begins H-1 edges after the sampling edge, and a forced write shows it in the cycle right after the write edge. The bench drives inputs on falling edges and samples on falling edges. After every sync it walks the whole window, cycle by cycle. In each cycle it compares the strobes with a function of H and k, where k counts the edges since the sync was sampled, so an early, late or widened pulse is caught. Configuration outputs are checked in the cycle after the write edge.

// File: rtl/agc_sync_pkg.sv
package agc_sync_pkg;
  // Commands from the control half to the countdown datapath
  typedef struct packed {
    logic load;      // start countdown from holdoffVal
    logic forceOne;  // jump the counter to one: strobe next cycle
  } syncCmd_t;
endpackage

// File: rtl/agc_sync_count.sv
module agc_sync_count #(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  agc_sync_pkg::syncCmd_t cmd,
  input  logic [CNT_W-1:0]     holdoffVal,
  output logic                 cntIsOne
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN)               cnt <= '0;
    else if (cmd.forceOne)   cnt <= ONE;
    else if (cmd.load)       cnt <= holdoffVal;
    else if (cnt != '0)      cnt <= cnt - ONE;
  end

  assign cntIsOne = (cnt == ONE);
endmodule

// File: rtl/agc_sync_ctrl.sv
module agc_sync_ctrl #(
  parameter int CNT_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   pinSync,
  input  logic                   softSync,
  input  logic [CNT_W-1:0]       holdoffVal,
  input  logic                   cfgWrite,
  input  logic                   cfgForce,
  input  logic                   cfgInitOnSync,
  input  logic                   cfgFirstOnly,
  input  logic                   cfgBypass,
  input  logic                   cfgClipMode,
  output agc_sync_pkg::syncCmd_t cmd,
  output logic                   initOnSyncReg,
  output logic                   firstOnlyReg,
  output logic                   firstSeen,
  output logic                   bypassReg,
  output logic                   clipModeReg
);
  logic syncReq;
  logic blocked;
  logic accept;

  assign syncReq = pinSync | softSync;
  assign blocked = firstOnlyReg & firstSeen;
  assign accept  = syncReq & ~cfgWrite & (holdoffVal != '0) & ~blocked;

  always_comb begin
    cmd.load     = accept;
    cmd.forceOne = cfgWrite & cfgForce;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      initOnSyncReg <= 1'b0;
      firstOnlyReg  <= 1'b0;
      bypassReg     <= 1'b0;
      clipModeReg   <= 1'b0;
      firstSeen     <= 1'b0;
    end else if (cfgWrite) begin
      initOnSyncReg <= cfgInitOnSync;
      firstOnlyReg  <= cfgFirstOnly;
      bypassReg     <= cfgBypass;
      clipModeReg   <= cfgClipMode;
      firstSeen     <= 1'b0;
    end else if (accept) begin
      firstSeen     <= 1'b1;
    end
  end
endmodule

// File: rtl/agc_sync_unit.sv
module agc_sync_unit #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pinSync,
  input  logic             softSync,
  input  logic [CNT_W-1:0] holdoffVal,
  input  logic             cfgWrite,
  input  logic             cfgForce,
  input  logic             cfgInitOnSync,
  input  logic             cfgFirstOnly,
  input  logic             cfgBypass,
  input  logic             cfgClipMode,
  output logic             updateStrobe,
  output logic             initStrobe,
  output logic             bypassOut,
  output logic             clipModeOut
);
  agc_sync_pkg::syncCmd_t cmd;
  logic initOnSyncReg;
  logic firstOnlyReg;
  logic firstSeen;
  logic cntIsOne;

  agc_sync_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .pinSync(pinSync), .softSync(softSync),
    .holdoffVal(holdoffVal), .cfgWrite(cfgWrite), .cfgForce(cfgForce),
    .cfgInitOnSync(cfgInitOnSync), .cfgFirstOnly(cfgFirstOnly),
    .cfgBypass(cfgBypass), .cfgClipMode(cfgClipMode), .cmd(cmd),
    .initOnSyncReg(initOnSyncReg), .firstOnlyReg(firstOnlyReg),
    .firstSeen(firstSeen), .bypassReg(bypassOut), .clipModeReg(clipModeOut)
  );

  agc_sync_count #(.CNT_W(CNT_W)) uCount (
    .clk(clk), .rstN(rstN), .cmd(cmd), .holdoffVal(holdoffVal),
    .cntIsOne(cntIsOne)
  );

  assign updateStrobe = cntIsOne;
  assign initStrobe   = cntIsOne & initOnSyncReg;
endmodule

// File: rtl/agc_sync_unit_chk.sv
module agc_sync_unit_chk #(
  parameter int CNT_W = 16
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   pinSync,
  input logic                   softSync,
  input logic [CNT_W-1:0]       holdoffVal,
  input logic                   cfgWrite,
  input logic                   cfgForce,
  input logic                   updateStrobe,
  input logic                   initStrobe,
  input logic                   bypassOut,
  input logic                   clipModeOut,
  input logic                   firstOnlyReg,
  input logic                   firstSeen,
  input agc_sync_pkg::syncCmd_t cmd
);
  AST_IMMEDIATE_HOLDOFF: assert property (@(posedge clk) disable iff (!rstN)
    ((pinSync || softSync) && !cfgWrite && holdoffVal == CNT_W'(1) && !(firstOnlyReg && firstSeen))
      |=> updateStrobe); // R3

  AST_FORCE_UPDATE: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrite && cfgForce) |=> updateStrobe); // R6

  AST_INIT_WITH_UPDATE: assert property (@(posedge clk) disable iff (!rstN)
    initStrobe |-> updateStrobe); // R7

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (updateStrobe && !cmd.forceOne && !(cmd.load && holdoffVal == CNT_W'(1)))
      |=> !updateStrobe); // R2

  AST_FIRST_ONLY_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (firstOnlyReg && firstSeen && !cfgWrite) |-> !cmd.load); // R8

  AST_ZERO_NEVER_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    (holdoffVal == '0) |-> !cmd.load); // R4

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWrite |=> ($stable(bypassOut) && $stable(clipModeOut))); // R9

  AST_WRITE_BEATS_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrite |-> !cmd.load); // R10
endmodule

bind agc_sync_unit agc_sync_unit_chk #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .pinSync(pinSync), .softSync(softSync),
  .holdoffVal(holdoffVal), .cfgWrite(cfgWrite), .cfgForce(cfgForce),
  .updateStrobe(updateStrobe), .initStrobe(initStrobe),
  .bypassOut(bypassOut), .clipModeOut(clipModeOut),
  .firstOnlyReg(firstOnlyReg), .firstSeen(firstSeen), .cmd(cmd)
);

// File: tb/tb_agc_sync_unit.sv
module tb_agc_sync_unit;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pinSync = 1'b0, softSync = 1'b0;
  logic [CNT_W-1:0] holdoffVal = '0;
  logic cfgWrite = 1'b0, cfgForce = 1'b0, cfgInitOnSync = 1'b0;
  logic cfgFirstOnly = 1'b0, cfgBypass = 1'b0, cfgClipMode = 1'b0;
  logic updateStrobe, initStrobe, bypassOut, clipModeOut;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk; // 250 MHz

  agc_sync_unit #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .pinSync(pinSync), .softSync(softSync),
    .holdoffVal(holdoffVal), .cfgWrite(cfgWrite), .cfgForce(cfgForce),
    .cfgInitOnSync(cfgInitOnSync), .cfgFirstOnly(cfgFirstOnly),
    .cfgBypass(cfgBypass), .cfgClipMode(cfgClipMode),
    .updateStrobe(updateStrobe), .initStrobe(initStrobe),
    .bypassOut(bypassOut), .clipModeOut(clipModeOut)
  );

  // Expected strobe k edges after the sampling edge, for holdoff h
  function automatic bit expFire(int h, int k, bit accepted);
    return accepted && h > 0 && k == h - 1;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic writeCfg(bit force_, bit init, bit first, bit byp, bit clip, bit alsoSync);
    cfgWrite = 1'b1; cfgForce = force_; cfgInitOnSync = init;
    cfgFirstOnly = first; cfgBypass = byp; cfgClipMode = clip;
    pinSync = alsoSync;
    tick();
    cfgWrite = 1'b0; cfgForce = 1'b0; pinSync = 1'b0;
  endtask

  // Issue one sync and walk its whole window
  task automatic syncRun(int h, bit usePin, bit accepted, bit init, string req);
    int span;
    holdoffVal = CNT_W'(h);
    pinSync = usePin; softSync = !usePin;
    tick();
    pinSync = 1'b0; softSync = 1'b0;
    span = (h > 0) ? h : 6;
    for (int k = 0; k <= span; k++) begin
      check(req, $sformatf("updateStrobe h=%0d k=%0d", h, k),
            int'(updateStrobe), int'(expFire(h, k, accepted)));
      check("R7", $sformatf("initStrobe h=%0d k=%0d", h, k),
            int'(initStrobe), int'(expFire(h, k, accepted) && init));
      if (k < span) tick();
    end
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) tick();
    // R1 reset state
    check("R1", "updateStrobe", int'(updateStrobe), 0);
    check("R1", "initStrobe", int'(initStrobe), 0);
    check("R1", "bypassOut", int'(bypassOut), 0);
    check("R1", "clipModeOut", int'(clipModeOut), 0);
    rstN = 1'b1;
    tick();
    check("R1", "updateStrobe idle", int'(updateStrobe), 0);

    // R2 pin and soft sync countdowns
    syncRun(5, 1'b1, 1'b1, 1'b0, "R2");
    syncRun(3, 1'b0, 1'b1, 1'b0, "R2");
    // R3 immediate
    syncRun(1, 1'b1, 1'b1, 1'b0, "R3");
    // R4 zero never syncs
    syncRun(0, 1'b0, 1'b0, 1'b0, "R4");

    // R5 retrigger: first H=6, second H=4 three edges later
    holdoffVal = CNT_W'(6); pinSync = 1'b1; tick(); pinSync = 1'b0;
    tick(); tick();
    holdoffVal = CNT_W'(4); softSync = 1'b1; tick(); softSync = 1'b0;
    for (int k = 0; k <= 4; k++) begin
      check("R5", $sformatf("retrigger k=%0d", k), int'(updateStrobe), int'(k == 3));
      tick();
    end

    // R6 forced update, R9 config outputs
    writeCfg(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    check("R6", "forced updateStrobe", int'(updateStrobe), 1);
    check("R9", "bypassOut", int'(bypassOut), 1);
    check("R9", "clipModeOut", int'(clipModeOut), 1);
    tick();
    check("R6", "forced strobe one cycle", int'(updateStrobe), 0);

    // R7 init on sync
    writeCfg(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R9", "bypassOut cleared", int'(bypassOut), 0);
    syncRun(4, 1'b1, 1'b1, 1'b1, "R7");
    writeCfg(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R7", "forced initStrobe", int'(initStrobe), 1);
    tick();

    // R8 first only
    writeCfg(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    syncRun(3, 1'b1, 1'b1, 1'b0, "R8");
    syncRun(3, 1'b1, 1'b0, 1'b0, "R8");
    syncRun(2, 1'b0, 1'b0, 1'b0, "R8");
    writeCfg(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    syncRun(2, 1'b0, 1'b1, 1'b0, "R8");

    // R10 sync during write ignored
    writeCfg(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    holdoffVal = CNT_W'(1);
    writeCfg(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    for (int k = 0; k < 3; k++) begin
      check("R10", $sformatf("sync with write k=%0d", k), int'(updateStrobe), 0);
      tick();
    end

    // Random mix
    for (int i = 0; i < 40; i++) begin
      int h = $urandom_range(1, 12);
      bit pin = 1'($urandom_range(0, 1));
      bit init = 1'($urandom_range(0, 1));
      bit byp = 1'($urandom_range(0, 1));
      bit clip = 1'($urandom_range(0, 1));
      writeCfg(1'b0, init, 1'b0, byp, clip, 1'b0);
      check("R9", "random bypassOut", int'(bypassOut), int'(byp));
      check("R9", "random clipModeOut", int'(clipModeOut), int'(clip));
      syncRun(h, pin, 1'b1, init, "R2");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule